// File: doc/BRIEF.md
# Synchronised Tick Counter Register Slave

This block is a small read-only timer peripheral for a register bus. It keeps a free-running 32-bit count of slow-clock ticks, delivered as a one-cycle tick-enable in the bus clock domain, and exposes two registers: a fixed revision code and the live count. Software reads the count either with one 32-bit access or with two 16-bit accesses. The low-half read captures the upper half into a shadow register, so the later high-half read gives a value that matches the first half even when the count carries between the two accesses.

All writes are rejected. Byte-sized accesses and reads of unmapped offsets are also rejected. A rejected access returns zero data together with an error pulse. Every access gets a registered response one clock after its strobe.

Top module: `sync_count_slave`

## Requirements
- R1: After reset, bus_resp_o, bus_err_o and bus_rdata_o are zero, the tick count is zero and the shadow halfword is zero.
- R2: The count increases by exactly one (modulo 2^32) for every clock cycle in which tick_en_i is high, and holds otherwise. A read in a cycle where tick_en_i is high returns the value from before that tick.
- R3: A read with bus_size_i = 2 (word) at offset 0x00 returns 0x00000021 without error.
- R4: A word read at offset 0x10 returns the tick count without error.
- R5: A read with bus_size_i = 1 (halfword) and address bit 1 clear returns, in bits 15:0 with bits 31:16 zero, the low half of the register at the address with bits 1:0 cleared. It also stores that register's upper 16 bits in the shadow halfword.
- R6: A halfword read with address bit 1 set returns the shadow halfword in bits 15:0, with bits 31:16 zero, whatever the live count is now. It reports no error.
- R7: Any access with bus_wr_i high, at any size or offset, gives an error with zero data and leaves the count and the shadow halfword unchanged.
- R8: A read with bus_size_i = 0 (byte) or 3 (reserved) gives an error with zero data and leaves the shadow halfword unchanged.
- R9: A word read at any offset other than 0x00 or 0x10 gives an error with zero data. A low-half read whose aligned offset is unmapped also gives an error with zero data, and it sets the shadow halfword to zero.
- R10: bus_resp_o pulses for one cycle, one clock after each strobe, and stays low when no strobe was given. bus_err_o is high only together with bus_resp_o.
- R11: Word reads leave the shadow halfword unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 1 | One-cycle enable per slow-clock tick |
| bus_addr_i | input | ADDR_W (8) | Byte address of the access |
| bus_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_rdata_o | output | DATA_W (32) | Registered read data |
| bus_resp_o | output | 1 | Response pulse, one clock after a strobe |
| bus_err_o | output | 1 | Error pulse, coincident with the response |

## Verification
The assertions check several properties on every clock cycle. The count steps by one on a tick and holds without one. Writes always end in an error and never move the count or the shadow. Byte-sized and reserved-size reads raise an error. Word reads leave the shadow alone. The revision and count words return the right data. No response appears without a strobe. Only the bench scenarios can show the coherent split read across a carry out of the low half, the clearing of the shadow by an unmapped low-half read, and the reset values seen through the bus.

// File: rtl/sync_cnt_pkg.sv
package sync_cnt_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } bus_size_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_REV  = 2'd1,
        SEL_CNT  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic       acc;
        logic       bad;
        reg_sel_e   sel;
        logic       half_lo;
        logic       half_hi;
        logic       word;
    } dec_t;

endpackage

// File: rtl/sync_cnt_counter.sv
module sync_cnt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_en_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (tick_en_i) begin
            count_d = count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/sync_cnt_decode.sv
module sync_cnt_decode
    import sync_cnt_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] REV_OFS = 32'h00,
    parameter logic [31:0] CNT_OFS = 32'h10
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output dec_t              dec_o
);
    localparam logic [ADDR_W-1:0] REV_A = REV_OFS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] CNT_A = CNT_OFS[ADDR_W-1:0];

    logic [ADDR_W-1:0] aligned;
    reg_sel_e          match_sel;

    always_comb begin
        aligned = {addr_i[ADDR_W-1:2], 2'b00};
        if (aligned == REV_A) begin
            match_sel = SEL_REV;
        end else if (aligned == CNT_A) begin
            match_sel = SEL_CNT;
        end else begin
            match_sel = SEL_NONE;
        end
    end

    always_comb begin
        dec_o         = '0;
        dec_o.sel     = SEL_NONE;
        dec_o.acc     = rd_i | wr_i;
        if (wr_i) begin
            dec_o.bad = 1'b1;
        end else if (rd_i) begin
            unique case (bus_size_e'(size_i))
                SZ_HALF: begin
                    if (addr_i[1]) begin
                        dec_o.half_hi = 1'b1;
                    end else begin
                        dec_o.half_lo = 1'b1;
                        dec_o.sel     = match_sel;
                        dec_o.bad     = (match_sel == SEL_NONE);
                    end
                end
                SZ_WORD: begin
                    dec_o.word = 1'b1;
                    if (addr_i[1:0] == 2'b00) begin
                        dec_o.sel = match_sel;
                    end
                    dec_o.bad = (addr_i[1:0] != 2'b00) || (match_sel == SEL_NONE);
                end
                default: begin
                    dec_o.bad = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/sync_count_slave.sv
module sync_count_slave
    import sync_cnt_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] REV_OFS   = 32'h00,
    parameter logic [31:0] CNT_OFS   = 32'h10,
    parameter logic [31:0] REV_VALUE = 32'h21
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_en_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [1:0]        bus_size_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_resp_o,
    output logic              bus_err_o
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic              resp;
        logic              err;
        logic [DATA_W-1:0] rdata;
        logic [HALF_W-1:0] shadow;
    } state_t;

    state_t            state_d, state_q;
    dec_t              dec;
    logic [DATA_W-1:0] count_w;
    logic [DATA_W-1:0] reg_val;

    sync_cnt_counter #(.CNT_W(DATA_W)) u_counter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_en_i (tick_en_i),
        .count_o   (count_w)
    );

    sync_cnt_decode #(
        .ADDR_W  (ADDR_W),
        .REV_OFS (REV_OFS),
        .CNT_OFS (CNT_OFS)
    ) u_decode (
        .addr_i (bus_addr_i),
        .size_i (bus_size_i),
        .rd_i   (bus_rd_i),
        .wr_i   (bus_wr_i),
        .dec_o  (dec)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_REV: reg_val = REV_VALUE[DATA_W-1:0];
            SEL_CNT: reg_val = count_w;
            default: reg_val = '0;
        endcase
    end

    always_comb begin
        state_d      = state_q;
        state_d.resp = dec.acc;
        state_d.err  = dec.acc & dec.bad;
        if (dec.half_lo) begin
            state_d.shadow = reg_val[DATA_W-1:HALF_W];
        end
        if (dec.acc) begin
            if (dec.bad) begin
                state_d.rdata = '0;
            end else if (dec.half_hi) begin
                state_d.rdata = {{HALF_W{1'b0}}, state_q.shadow};
            end else if (dec.half_lo) begin
                state_d.rdata = {{HALF_W{1'b0}}, reg_val[HALF_W-1:0]};
            end else begin
                state_d.rdata = reg_val;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata_o = state_q.rdata;
    assign bus_resp_o  = state_q.resp;
    assign bus_err_o   = state_q.err;
endmodule

// File: rtl/sync_cnt_checker.sv
module sync_cnt_checker #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] REV_OFS   = 32'h00,
    parameter logic [31:0] CNT_OFS   = 32'h10,
    parameter logic [31:0] REV_VALUE = 32'h21
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_en_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [1:0]        bus_size_i,
    input logic              bus_rd_i,
    input logic              bus_wr_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              bus_resp_o,
    input logic              bus_err_o,
    input logic [DATA_W-1:0] count_i,
    input logic [DATA_W/2-1:0] shadow_i
);
    logic rd_only, word_rd;
    assign rd_only = bus_rd_i && !bus_wr_i;
    assign word_rd = rd_only && (bus_size_i == 2'd2);

    a_r2_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_en_i |=> count_i == $past(count_i) + DATA_W'(1));

    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_en_i |=> $stable(count_i));

    a_r3_revision: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_rd && bus_addr_i == REV_OFS[ADDR_W-1:0]) |=>
            (bus_rdata_o == REV_VALUE[DATA_W-1:0] && !bus_err_o));

    a_r4_count_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_rd && bus_addr_i == CNT_OFS[ADDR_W-1:0]) |=>
            (bus_rdata_o == $past(count_i) && !bus_err_o));

    a_r7_write_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_wr_i |=> (bus_resp_o && bus_err_o && bus_rdata_o == '0));

    a_r7_write_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_wr_i |=> $stable(shadow_i));

    a_r8_byte_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_only && (bus_size_i == 2'd0 || bus_size_i == 2'd3)) |=>
            (bus_err_o && bus_rdata_o == '0 && $stable(shadow_i)));

    a_r10_err_in_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_err_o |-> bus_resp_o);

    a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_rd_i || bus_wr_i) |=> !bus_resp_o);

    a_r11_word_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_rd |=> $stable(shadow_i));
endmodule

bind sync_count_slave sync_cnt_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REV_OFS   (REV_OFS),
    .CNT_OFS   (CNT_OFS),
    .REV_VALUE (REV_VALUE)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_en_i   (tick_en_i),
    .bus_addr_i  (bus_addr_i),
    .bus_size_i  (bus_size_i),
    .bus_rd_i    (bus_rd_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_resp_o  (bus_resp_o),
    .bus_err_o   (bus_err_o),
    .count_i     (count_w),
    .shadow_i    (state_q.shadow)
);

// File: tb/sync_count_slave_tb.sv
module sync_count_slave_tb;
    localparam logic [1:0] SZB = 2'd0, SZH = 2'd1, SZW = 2'd2, SZR = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  addr = '0;
    logic [1:0]  size = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] rdata;
    logic        resp, err;

    int          checks = 0;
    int          fails = 0;
    logic [31:0] exp_cnt = '0;

    always #2 clk = ~clk;

    sync_count_slave u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_en_i   (tick),
        .bus_addr_i  (addr),
        .bus_size_i  (size),
        .bus_rd_i    (rd),
        .bus_wr_i    (wr),
        .bus_rdata_o (rdata),
        .bus_resp_o  (resp),
        .bus_err_o   (err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
        exp_cnt += 32'(n);
    endtask

    task automatic access(input logic r, input logic w, input logic [7:0] a,
                          input logic [1:0] sz, input logic tk,
                          output logic [31:0] d, output logic rs, output logic e);
        rd = r; wr = w; addr = a; size = sz; tick = tk;
        @(negedge clk);
        rd = 1'b0; wr = 1'b0; tick = 1'b0;
        d = rdata; rs = resp; e = err;
        if (tk) exp_cnt += 32'd1;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic rs, e;
        check("R1 rdata", rdata, 32'h0);
        check("R1 resp", {31'h0, resp}, 32'h0);
        check("R1 err", {31'h0, err}, 32'h0);
        access(1, 0, 8'h10, SZW, 0, d, rs, e);
        check("R1 count zero", d, 32'h0);
        access(1, 0, 8'h02, SZH, 0, d, rs, e);
        check("R1 shadow zero", d, 32'h0);
    endtask

    task automatic t_revision();
        logic [31:0] d; logic rs, e;
        access(1, 0, 8'h00, SZW, 0, d, rs, e);
        check("R3 data", d, 32'h21);
        check("R3 err", {31'h0, e}, 32'h0);
        check("R10 resp", {31'h0, rs}, 32'h1);
        access(1, 0, 8'h00, SZH, 0, d, rs, e);
        check("R5 rev low", d, 32'h21);
        access(1, 0, 8'h02, SZH, 0, d, rs, e);
        check("R6 rev shadow", d, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] d; logic rs, e;
        ticks(37);
        access(1, 0, 8'h10, SZW, 0, d, rs, e);
        check("R4 count", d, exp_cnt);
        check("R4 err", {31'h0, e}, 32'h0);
        access(1, 0, 8'h10, SZW, 1, d, rs, e);
        check("R2 read before tick", d, exp_cnt - 32'd1);
        access(1, 0, 8'h10, SZW, 0, d, rs, e);
        check("R2 tick counted", d, exp_cnt);
    endtask

    task automatic t_split();
        logic [31:0] d; logic rs, e;
        ticks(int'(32'h0000FFF0 - exp_cnt));
        access(1, 0, 8'h10, SZH, 0, d, rs, e);
        check("R5 low half", d, 32'h0000FFF0);
        ticks(32);
        access(1, 0, 8'h12, SZH, 0, d, rs, e);
        check("R6 coherent high", d, 32'h0);
        check("R6 err", {31'h0, e}, 32'h0);
        access(1, 0, 8'h10, SZH, 0, d, rs, e);
        check("R5 low after carry", d, exp_cnt & 32'hFFFF);
        access(1, 0, 8'h12, SZH, 0, d, rs, e);
        check("R6 high after carry", d, exp_cnt >> 16);
    endtask

    task automatic t_writes();
        logic [31:0] d; logic rs, e;
        access(0, 1, 8'h10, SZW, 0, d, rs, e);
        check("R7 word write err", {30'h0, rs, e}, 32'h3);
        check("R7 word write data", d, 32'h0);
        access(0, 1, 8'h00, SZH, 0, d, rs, e);
        check("R7 half write err", {31'h0, e}, 32'h1);
        access(1, 1, 8'h10, SZH, 0, d, rs, e);
        check("R7 rd+wr err", {31'h0, e}, 32'h1);
        access(1, 0, 8'h12, SZH, 0, d, rs, e);
        check("R7 shadow kept", d, 32'h1);
        access(1, 0, 8'h10, SZW, 0, d, rs, e);
        check("R7 count kept", d, exp_cnt);
    endtask

    task automatic t_byte();
        logic [31:0] d; logic rs, e;
        access(1, 0, 8'h00, SZB, 0, d, rs, e);
        check("R8 byte err", {31'h0, e}, 32'h1);
        check("R8 byte data", d, 32'h0);
        access(1, 0, 8'h10, SZR, 0, d, rs, e);
        check("R8 reserved err", {31'h0, e}, 32'h1);
        access(1, 0, 8'h12, SZH, 0, d, rs, e);
        check("R8 shadow kept", d, 32'h1);
    endtask

    task automatic t_word_shadow();
        logic [31:0] d; logic rs, e;
        ticks(5);
        access(1, 0, 8'h00, SZW, 0, d, rs, e);
        access(1, 0, 8'h10, SZW, 0, d, rs, e);
        access(1, 0, 8'h12, SZH, 0, d, rs, e);
        check("R11 shadow after word reads", d, 32'h1);
    endtask

    task automatic t_bad_offset();
        logic [31:0] d; logic rs, e;
        access(1, 0, 8'h04, SZW, 0, d, rs, e);
        check("R9 word 0x04 err", {31'h0, e}, 32'h1);
        check("R9 word 0x04 data", d, 32'h0);
        access(1, 0, 8'h12, SZW, 0, d, rs, e);
        check("R9 word 0x12 err", {31'h0, e}, 32'h1);
        access(1, 0, 8'h08, SZH, 0, d, rs, e);
        check("R9 half low unmapped err", {31'h0, e}, 32'h1);
        access(1, 0, 8'h0A, SZH, 0, d, rs, e);
        check("R9 shadow cleared", d, 32'h0);
    endtask

    task automatic t_idle();
        logic [31:0] d; logic rs, e;
        access(0, 1, 8'h00, SZW, 0, d, rs, e);
        @(negedge clk);
        check("R10 resp single pulse", {30'h0, resp, err}, 32'h0);
        check("R10 rdata held", rdata, 32'h0);
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_revision();
        t_count();
        t_split();
        t_writes();
        t_byte();
        t_word_shadow();
        t_bad_offset();
        t_idle();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule